// File: doc/BRIEF.md
# External Interrupt Line Controller

The controller watches up to 32 external interrupt inputs and turns each one into a latched, maskable interrupt request towards a single CPU. Every line has its own sense selection: low level, high level, falling edge, rising edge or both edges. Inputs are first brought into the controller clock domain through two flops. The level or edge is then evaluated synchronously. A detected event sets a bit in a detect register, and that bit stays set until software clears it by writing a one.

A mask register gates each line towards its interrupt output. The mask is changed through two write locations: one only sets bits and the other only clears them, so a read-modify-write is never needed. Software reaches everything through a plain 32-bit register bus. Writes take effect on the clock edge. Reads are combinational from the register state.

Top module: `ext_irq_ctrl`

## Requirements
- R1: In an edge mode, a qualifying edge on the input sets that line's detect bit. Rising is code 0x08, falling is code 0x04 and both edges is code 0x0C, held in bits [5:0] of the line's configuration word at offset 0x180 + 4*line. The detect register reads at offset 0x100, one bit per line, line n at bit n.
- R2: In a level mode, a line whose synchronised input is at its active level sets its detect bit. Low is code 0x01 and high is code 0x02. The bit stays set after the input leaves the active level.
- R3: Writing ones at offset 0x08 sets those enable bits. Writing ones at offset 0x04 clears them. Zero bits leave the mask unchanged. Offset 0x04 reads back the mask.
- R4: A configuration word reads back the full 32-bit value last written to it. Any value of bits [5:0] other than the five listed codes detects nothing.
- R5: Writing ones at offset 0x100 clears those detect bits. In edge modes a cleared bit stays clear until a new qualifying edge arrives. Detect bits never fall without such a write.
- R6: In a level mode, a detect bit cleared while its input is still active reads zero for one cycle and is set again on the following clock.
- R7: If a qualifying edge and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R8: After reset, the enable mask, the detect bits, all configuration words and all interrupt outputs are zero.
- R9: Offset 0x00 reads detect AND enable. Each interrupt output equals the previous cycle's detect AND enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NLINES | Raw external interrupt inputs |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | AW | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | NLINES | Per-line interrupt requests to the CPU |

## Verification
The checker evaluates several rules on every cycle:
- each interrupt output follows the previous detect-and-enable state;
- set writes and clear writes act on exactly the written mask bits;
- detect bits never fall unless a clear write targets them;
- the state is zero when reset is released.

The sense decoding can only be shown by the bench's scenarios. That covers every code including an invalid one, the latching of levels, the one-cycle gap before a level re-asserts, and the edge-versus-clear collision. The bench sweeps all lines through several before/after input patterns for each code.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NLINES = 32,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NLINES-1:0] irq_out
);

  localparam int OFS_REQ  = 'h000;
  localparam int OFS_MCLR = 'h004;
  localparam int OFS_MSET = 'h008;
  localparam int OFS_DET  = 'h100;
  localparam int OFS_CFG  = 'h180;
  localparam int IW       = AW - 2;

  localparam logic [5:0] SENSE_LO   = 6'h01;
  localparam logic [5:0] SENSE_HI   = 6'h02;
  localparam logic [5:0] SENSE_FALL = 6'h04;
  localparam logic [5:0] SENSE_RISE = 6'h08;
  localparam logic [5:0] SENSE_BOTH = 6'h0C;

  logic [NLINES-1:0] sync1, sync2, sync3;
  logic [NLINES-1:0] en_q, det_q;
  logic [NLINES-1:0] lvl_hit, edg_hit, det_clr;
  logic [31:0]       cfg_q [NLINES];

  logic          word_ok;
  logic [IW-1:0] word_idx, cfg_idx;
  logic          cfg_sel;

  assign word_ok  = bus_addr[1:0] == 2'b00;
  assign word_idx = bus_addr[AW-1:2];
  assign cfg_idx  = word_idx - IW'(OFS_CFG / 4);
  assign cfg_sel  = word_ok && (word_idx >= IW'(OFS_CFG / 4)) && (cfg_idx < IW'(NLINES));

  wire wr_mset = bus_wr && word_ok && word_idx == IW'(OFS_MSET / 4);
  wire wr_mclr = bus_wr && word_ok && word_idx == IW'(OFS_MCLR / 4);
  wire wr_det  = bus_wr && word_ok && word_idx == IW'(OFS_DET / 4);

  assign det_clr = wr_det ? bus_wdata[NLINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_comb begin
      lvl_hit[i] = 1'b0;
      edg_hit[i] = 1'b0;
      case (cfg_q[i][5:0])
        SENSE_LO:   lvl_hit[i] = ~sync2[i];
        SENSE_HI:   lvl_hit[i] = sync2[i];
        SENSE_FALL: edg_hit[i] = sync3[i] & ~sync2[i];
        SENSE_RISE: edg_hit[i] = ~sync3[i] & sync2[i];
        SENSE_BOTH: edg_hit[i] = sync3[i] ^ sync2[i];
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[i] <= '0;
      else if (bus_wr && cfg_sel && cfg_idx == IW'(i))
        cfg_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      det_q   <= '0;
      irq_out <= '0;
    end else begin
      if (wr_mset) en_q <= en_q | bus_wdata[NLINES-1:0];
      else if (wr_mclr) en_q <= en_q & ~bus_wdata[NLINES-1:0];
      det_q   <= (det_q & ~det_clr) | edg_hit | (lvl_hit & ~det_clr);
      irq_out <= det_q & en_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (word_ok) begin
      if (word_idx == IW'(OFS_REQ / 4))       bus_rdata[NLINES-1:0] = det_q & en_q;
      else if (word_idx == IW'(OFS_MCLR / 4)) bus_rdata[NLINES-1:0] = en_q;
      else if (word_idx == IW'(OFS_DET / 4))  bus_rdata[NLINES-1:0] = det_q;
    end
    for (int i = 0; i < NLINES; i++)
      if (cfg_sel && cfg_idx == IW'(i)) bus_rdata = cfg_q[i];
  end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NLINES = 32,
  parameter int AW     = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NLINES-1:0] irq_out,
  input logic [NLINES-1:0] en_q,
  input logic [NLINES-1:0] det_q
);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(det_q & en_q));

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h008)) |=>
      ((en_q & $past(bus_wdata[NLINES-1:0])) == $past(bus_wdata[NLINES-1:0])));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h004)) |=> ((en_q & $past(bus_wdata[NLINES-1:0])) == '0));

  // R5
  det_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'('h100)) |=> (($past(det_q) & ~det_q) == '0));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (en_q == '0 && det_q == '0 && irq_out == '0));

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NLINES(NLINES), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .en_q(en_q), .det_q(det_q)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  localparam int N  = 8;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NLINES(N), .AW(AW)) i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] data);
    bus_addr = AW'(addr);
    #0.5;
    data = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [N-1:0] expect_det(logic [5:0] code, logic [N-1:0] b, logic [N-1:0] a);
    case (code)
      6'h01:   return ~b | ~a;
      6'h02:   return b | a;
      6'h04:   return b & ~a;
      6'h08:   return ~b & a;
      6'h0C:   return b ^ a;
      default: return '0;
    endcase
  endfunction

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [5:0] codes [7] = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h03, 6'h00};
    logic [N-1:0] bs [3] = '{8'h00, 8'hFF, 8'h5A};
    logic [N-1:0] as [4] = '{8'h0F, 8'h3C, 8'hF0, 8'hA5};

    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R8 reset state
    rd('h000, v); check("R8 req", v, 0);
    rd('h004, v); check("R8 mask", v, 0);
    rd('h100, v); check("R8 det", v, 0);
    for (int i = 0; i < N; i++) begin
      rd('h180 + 4*i, v); check("R8 cfg", v, 0);
    end
    check("R8 irq_out", 32'(irq_out), 0);

    // R3 enable set/clear
    wr('h008, 32'hA5); rd('h004, v); check("R3 set", v, 32'hA5);
    wr('h004, 32'h05); rd('h004, v); check("R3 clear", v, 32'hA0);
    wr('h008, 32'h00); rd('h004, v); check("R3 set zero", v, 32'hA0);
    wr('h004, 32'h00); rd('h004, v); check("R3 clear zero", v, 32'hA0);
    wr('h004, 32'hFF); wr('h008, 32'h3C);

    // R4 config readback
    for (int i = 0; i < N; i++) wr('h180 + 4*i, 32'h1234_5600 + 32'(i * 'h0101_0100) + 32'h3F);
    for (int i = 0; i < N; i++) begin
      rd('h180 + 4*i, v); check("R4 readback", v, 32'h1234_5600 + 32'(i * 'h0101_0100) + 32'h3F);
    end

    // R1 R2 R4 R9 sweep over codes and input patterns
    foreach (codes[c]) foreach (bs[bi]) foreach (as[ai]) begin
      logic [N-1:0] e;
      for (int i = 0; i < N; i++) wr('h180 + 4*i, 32'hC000_0000 | 32'(codes[c]));
      irq_in = bs[bi];
      idle(6);
      wr('h100, 32'hFF);
      idle(1);
      irq_in = as[ai];
      idle(6);
      e = expect_det(codes[c], bs[bi], as[ai]);
      rd('h100, v); check("R1/R2/R4 det", v, 32'(e));
      rd('h000, v); check("R9 req", v, 32'(e & 8'h3C));
      check("R9 irq_out", 32'(irq_out), 32'(e & 8'h3C));
    end

    // R5 edge clear stays clear
    for (int i = 0; i < N; i++) wr('h180 + 4*i, 32'h08);
    irq_in = '0; idle(6); wr('h100, 32'hFF);
    irq_in = 8'h01; idle(6);
    rd('h100, v); check("R5 set", v, 32'h01);
    wr('h100, 32'h01);
    rd('h100, v); check("R5 cleared", v, 0);
    idle(5);
    rd('h100, v); check("R5 stays clear", v, 0);

    // R6 level re-assert after one cycle
    wr('h180, 32'h02); idle(4);
    rd('h100, v); check("R6 pre", v, 32'h01);
    wr('h100, 32'h01);
    rd('h100, v); check("R6 gap", v, 0);
    idle(1);
    rd('h100, v); check("R6 reassert", v, 32'h01);

    // R7 edge and clear in same cycle
    wr('h180, 32'h08);
    irq_in = '0; idle(6);
    irq_in = 8'h01; idle(6);
    irq_in = '0; idle(6);
    rd('h100, v); check("R7 pre", v, 32'h01);
    irq_in = 8'h01;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr('h100, 32'h01);
    rd('h100, v); check("R7 collision", v, 32'h01);

    finish_run();
  end
endmodule